// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits behind a host bridge's configuration index port and data window. Software writes a 32-bit index value into the block and then reads or writes through a 4 KiB data window. For each window access the block merges the stored index with the low bits of the access address and produces a normalised configuration address. In that address the device number occupies bits [15:11], the function number bits [10:8] and the register offset bits [7:0].

Three index formats are accepted and are told apart by index bits 31 and 0. With bit 31 set, the index passes through almost unchanged. With bit 31 clear and bit 0 set, the index is already in type-1 form and only its low three bits are replaced. With both bits clear, the index is type-0 with a one-hot device select in bits [31:11]. The block locates the lowest set bit there and encodes its bit number as the device number.

The translated request leaves the block one cycle after the access as a single-cycle read or write strobe. The strobe carries the write data and byte enables unchanged. Read data and its acknowledge flow back from the configuration targets to the window without modification.

Top module: `cfg_addr_xlate`

## Requirements
- R1: The index register resets to 0 and `idx_rdata` shows exactly the value written by `idx_wr` from the cycle after the write.
- R2: An access uses the index value held before its clock edge. An index write in the same cycle affects only later accesses.
- R3: An access with `acc_write`=0 gives `req_rd`=1 for exactly the next cycle, and one with `acc_write`=1 gives `req_wr`=1 for exactly the next cycle. With no access, both strobes stay 0.
- R4: Pass-through format (index bit 31 = 1): `req_addr` = index OR'd with access address bits [1:0] in bits [1:0].
- R5: Type-1 format (index bit 31 = 0, bit 0 = 1): `req_addr` = index bits [31:3] followed by access address bits [2:0].
- R6: Type-0 format (index bits 31 and 0 both 0) with some bit of index [31:11] set: `req_addr[15:11]` is the bit number (11 to 30) of the lowest such set bit, and `req_addr[31:16]` = 0.
- R7: Type-0 format with index [31:11] all zero: `req_addr[31:11]` is all ones.
- R8: In type-0 format, `req_addr[10:8]` carries the function number from index [10:8], `req_addr[7:3]` = index [7:3], and `req_addr[2:0]` = access address [2:0].
- R9: `req_wdata` and `req_be` equal the access's data and byte enables, with little-endian lanes (`be[i]` covers data bits [8i+7:8i]). `req_addr`, `req_wdata` and `req_be` hold their values while no access occurs.
- R10: `acc_rdata` equals `cpl_rdata` and `acc_ack` equals `cpl_ack` in the same cycle.
- R11: Access address bits above bit 2 have no effect on the translated address in any format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_wr | input | 1 | Index register write strobe |
| idx_wdata | input | IDX_W | Index value to write |
| idx_rdata | output | IDX_W | Current index register value |
| acc_valid | input | 1 | Data window access this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | WIN_AW | Offset of the access inside the data window |
| acc_wdata | input | DATA_W | Write data of the access |
| acc_be | input | DATA_W/8 | Byte enables of the access |
| acc_rdata | output | DATA_W | Read data returned to the window |
| acc_ack | output | 1 | Read data valid toward the window |
| req_rd | output | 1 | Configuration read strobe, one cycle |
| req_wr | output | 1 | Configuration write strobe, one cycle |
| req_addr | output | IDX_W | Translated configuration address |
| req_wdata | output | DATA_W | Forwarded write data |
| req_be | output | DATA_W/8 | Forwarded byte enables |
| cpl_rdata | input | DATA_W | Read data from the configuration target |
| cpl_ack | input | 1 | Read data valid from the configuration target |

## Verification
The bench builds two copies with the default widths (32-bit index and data, 12-bit window, device select starting at bit 11). One copy uses the scanning lowest-bit finder (`FIND_MODE`=0) and the other the isolate-and-encode finder (`FIND_MODE`=1), so both generate variants are compared against the same expected stream. This sweeps every one-hot select position from bit 11 to bit 30, multi-bit selects and the empty select for both encoders. Because the defaults put bit 31 and bit 0 at the format-select positions, all three index formats, the all-ones fill and same-cycle index write are reachable.

// File: rtl/cfg_addr_xlate_pkg.sv
package cfg_addr_xlate_pkg;

   typedef enum logic [1:0] {
      XF_PASS  = 2'd0,
      XF_TYPE1 = 2'd1,
      XF_TYPE0 = 2'd2
   } xlate_fmt_e;

   localparam int PASS_LO_W = 2;
   localparam int T1_LO_W   = 3;
   localparam int FUNC_W    = 3;

   function automatic xlate_fmt_e classify_fmt(input logic top_bit, input logic low_bit);
      if (top_bit)      return XF_PASS;
      else if (low_bit) return XF_TYPE1;
      else              return XF_TYPE0;
   endfunction

endpackage

// File: rtl/cfg_addr_xlate_idx.sv
module cfg_addr_xlate_idx #(
   parameter int IDX_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_val,
   output logic [IDX_W-1:0] idx_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     idx_q <= '0;
      else if (wr_en) idx_q <= wr_val;
   end
endmodule

// File: rtl/cfg_addr_xlate_lowbit.sv
module cfg_addr_xlate_lowbit #(
   parameter int IN_W  = 21,
   parameter int OUT_W = 5,
   parameter int MODE  = 0
) (
   input  logic [IN_W-1:0]  vec,
   output logic             hit,
   output logic [OUT_W-1:0] pos
);
   if (IN_W > (1 << OUT_W)) begin : g_bad_w
      $error("lowbit: OUT_W too narrow for IN_W");
   end
   if (MODE != 0 && MODE != 1) begin : g_bad_mode
      $error("lowbit: MODE must be 0 or 1");
   end

   assign hit = |vec;

   if (MODE == 0) begin : g_scan
      // descending scan: the last match written is the lowest set bit
      always_comb begin
         pos = '0;
         for (int i = IN_W - 1; i >= 0; i--) begin
            if (vec[i]) pos = OUT_W'(i);
         end
      end
   end else begin : g_isolate
      logic [IN_W-1:0] iso;
      assign iso = vec & ((~vec) + IN_W'(1));
      // iso is one-hot (or zero), so OR-ing indices is an encoder
      always_comb begin
         pos = '0;
         for (int i = 0; i < IN_W; i++) begin
            if (iso[i]) pos = pos | OUT_W'(i);
         end
      end
   end
endmodule

// File: rtl/cfg_addr_xlate_map.sv
module cfg_addr_xlate_map
   import cfg_addr_xlate_pkg::*;
#(
   parameter int IDX_W     = 32,
   parameter int DEV_LSB   = 11,
   parameter int FIND_MODE = 0
) (
   input  logic [IDX_W-1:0]   idx_q,
   input  logic [T1_LO_W-1:0] win_lo,
   output logic [IDX_W-1:0]   cfg_addr
);
   localparam int SRCH_W   = IDX_W - DEV_LSB;
   localparam int DEVNUM_W = $clog2(IDX_W);

   xlate_fmt_e          fmt;
   logic                sel_hit;
   logic [DEVNUM_W-1:0] sel_rel;
   logic [DEVNUM_W-1:0] dev_num;

   assign fmt = classify_fmt(idx_q[IDX_W-1], idx_q[0]);

   cfg_addr_xlate_lowbit #(
      .IN_W (SRCH_W),
      .OUT_W(DEVNUM_W),
      .MODE (FIND_MODE)
   ) u_find (
      .vec(idx_q[IDX_W-1:DEV_LSB]),
      .hit(sel_hit),
      .pos(sel_rel)
   );

   assign dev_num = sel_rel + DEVNUM_W'(DEV_LSB);

   always_comb begin
      cfg_addr = '0;
      unique case (fmt)
         XF_PASS: begin
            cfg_addr = idx_q | IDX_W'(win_lo[PASS_LO_W-1:0]);
         end
         XF_TYPE1: begin
            cfg_addr = {idx_q[IDX_W-1:T1_LO_W], win_lo};
         end
         XF_TYPE0: begin
            cfg_addr[T1_LO_W-1:0]       = win_lo;
            cfg_addr[DEV_LSB-1:T1_LO_W] = idx_q[DEV_LSB-1:T1_LO_W];
            if (sel_hit) cfg_addr[DEV_LSB +: DEVNUM_W] = dev_num;
            else         cfg_addr[IDX_W-1:DEV_LSB]     = '1;
         end
         default: cfg_addr = '0;
      endcase
   end
endmodule

// File: rtl/cfg_addr_xlate_req.sv
module cfg_addr_xlate_req #(
   parameter int IDX_W  = 32,
   parameter int DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic                  in_write,
   input  logic [IDX_W-1:0]      in_addr,
   input  logic [DATA_W-1:0]     in_wdata,
   input  logic [DATA_W/8-1:0]   in_be,
   output logic                  out_rd,
   output logic                  out_wr,
   output logic [IDX_W-1:0]      out_addr,
   output logic [DATA_W-1:0]     out_wdata,
   output logic [DATA_W/8-1:0]   out_be
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_rd <= 1'b0;
         out_wr <= 1'b0;
      end else begin
         out_rd <= in_valid & ~in_write;
         out_wr <= in_valid &  in_write;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_addr  <= '0;
         out_wdata <= '0;
         out_be    <= '0;
      end else if (in_valid) begin
         out_addr  <= in_addr;
         out_wdata <= in_wdata;
         out_be    <= in_be;
      end
   end
endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate
   import cfg_addr_xlate_pkg::*;
#(
   parameter int IDX_W     = 32,
   parameter int DATA_W    = 32,
   parameter int WIN_AW    = 12,
   parameter int DEV_LSB   = 11,
   parameter int FIND_MODE = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                idx_wr,
   input  logic [IDX_W-1:0]    idx_wdata,
   output logic [IDX_W-1:0]    idx_rdata,
   input  logic                acc_valid,
   input  logic                acc_write,
   input  logic [WIN_AW-1:0]   acc_addr,
   input  logic [DATA_W-1:0]   acc_wdata,
   input  logic [DATA_W/8-1:0] acc_be,
   output logic [DATA_W-1:0]   acc_rdata,
   output logic                acc_ack,
   output logic                req_rd,
   output logic                req_wr,
   output logic [IDX_W-1:0]    req_addr,
   output logic [DATA_W-1:0]   req_wdata,
   output logic [DATA_W/8-1:0] req_be,
   input  logic [DATA_W-1:0]   cpl_rdata,
   input  logic                cpl_ack
);
   localparam int DEVNUM_W = $clog2(IDX_W);

   if (DATA_W % 8 != 0) begin : g_bad_data
      $error("cfg_addr_xlate: DATA_W must be a multiple of 8");
   end
   if (WIN_AW < T1_LO_W + 1) begin : g_bad_win
      $error("cfg_addr_xlate: WIN_AW too small");
   end
   if (DEV_LSB < T1_LO_W + FUNC_W + 1) begin : g_bad_lsb
      $error("cfg_addr_xlate: DEV_LSB leaves no register offset");
   end
   if (DEV_LSB + DEVNUM_W > IDX_W - 1) begin : g_bad_idx
      $error("cfg_addr_xlate: IDX_W too narrow for device field");
   end

   logic [IDX_W-1:0] xaddr;
   logic             unused_hi;

   assign unused_hi = ^acc_addr[WIN_AW-1:T1_LO_W];

   cfg_addr_xlate_idx #(.IDX_W(IDX_W)) u_idx (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (idx_wr),
      .wr_val(idx_wdata),
      .idx_q (idx_rdata)
   );

   cfg_addr_xlate_map #(
      .IDX_W    (IDX_W),
      .DEV_LSB  (DEV_LSB),
      .FIND_MODE(FIND_MODE)
   ) u_map (
      .idx_q   (idx_rdata),
      .win_lo  (acc_addr[T1_LO_W-1:0]),
      .cfg_addr(xaddr)
   );

   cfg_addr_xlate_req #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (acc_valid),
      .in_write (acc_write),
      .in_addr  (xaddr),
      .in_wdata (acc_wdata),
      .in_be    (acc_be),
      .out_rd   (req_rd),
      .out_wr   (req_wr),
      .out_addr (req_addr),
      .out_wdata(req_wdata),
      .out_be   (req_be)
   );

   assign acc_rdata = cpl_rdata;
   assign acc_ack   = cpl_ack;
endmodule

// File: rtl/cfg_addr_xlate_chk.sv
module cfg_addr_xlate_chk #(
   parameter int IDX_W   = 32,
   parameter int DATA_W  = 32,
   parameter int WIN_AW  = 12,
   parameter int DEV_LSB = 11
) (
   input logic                clk,
   input logic                rst_n,
   input logic                idx_wr,
   input logic [IDX_W-1:0]    idx_wdata,
   input logic [IDX_W-1:0]    idx_rdata,
   input logic                acc_valid,
   input logic                acc_write,
   input logic [WIN_AW-1:0]   acc_addr,
   input logic [DATA_W-1:0]   acc_wdata,
   input logic [DATA_W/8-1:0] acc_be,
   input logic                req_rd,
   input logic                req_wr,
   input logic [IDX_W-1:0]    req_addr,
   input logic [DATA_W-1:0]   req_wdata,
   input logic [DATA_W/8-1:0] req_be
);
   logic is_t0;
   assign is_t0 = !idx_rdata[IDX_W-1] && !idx_rdata[0];

   a_r1_readback: assert property (@(posedge clk) disable iff (!rst_n)
      idx_wr |=> idx_rdata == $past(idx_wdata));

   a_r3_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write) |=> (req_rd && !req_wr));

   a_r3_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write) |=> (req_wr && !req_rd));

   a_r3_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (!req_rd && !req_wr));

   // R2 is covered too: idx_rdata in the antecedent is the pre-edge value
   a_r4_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && idx_rdata[IDX_W-1]) |=>
      req_addr == ($past(idx_rdata) | IDX_W'($past(acc_addr[1:0]))));

   a_r5_type1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !idx_rdata[IDX_W-1] && idx_rdata[0]) |=>
      req_addr == {$past(idx_rdata[IDX_W-1:3]), $past(acc_addr[2:0])});

   a_r7_no_select: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && is_t0 && idx_rdata[IDX_W-1:DEV_LSB] == '0) |=>
      (&req_addr[IDX_W-1:DEV_LSB]));

   a_r8_low_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && is_t0) |=>
      req_addr[DEV_LSB-1:0] == {$past(idx_rdata[DEV_LSB-1:3]), $past(acc_addr[2:0])});

   a_r9_payload: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> (req_wdata == $past(acc_wdata) && req_be == $past(acc_be)));

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> ($stable(req_addr) && $stable(req_wdata) && $stable(req_be)));
endmodule

bind cfg_addr_xlate cfg_addr_xlate_chk #(
   .IDX_W  (IDX_W),
   .DATA_W (DATA_W),
   .WIN_AW (WIN_AW),
   .DEV_LSB(DEV_LSB)
) u_chk (.*);

// File: tb/cfg_addr_xlate_test.sv
`timescale 1ns/1ps
module cfg_addr_xlate_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        idx_wr = 1'b0;
   logic [31:0] idx_wdata = '0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [11:0] acc_addr = '0;
   logic [31:0] acc_wdata = '0;
   logic [3:0]  acc_be = '0;
   logic [31:0] cpl_rdata = '0;
   logic        cpl_ack = 1'b0;

   logic [31:0] idx_rdata, acc_rdata, req_addr, req_wdata;
   logic        acc_ack, req_rd, req_wr;
   logic [3:0]  req_be;
   logic [31:0] idx_rdata_b, acc_rdata_b, req_addr_b, req_wdata_b;
   logic        acc_ack_b, req_rd_b, req_wr_b;
   logic [3:0]  req_be_b;

   int checks = 0;
   int fails  = 0;
   logic [31:0] shadow = '0;
   logic [31:0] last_addr = '0;

   typedef struct packed {
      logic        wr;
      logic [31:0] addr;
      logic [31:0] data;
      logic [3:0]  be;
   } exp_t;
   exp_t sb[$];

   always #10 clk = ~clk;

   cfg_addr_xlate #(.FIND_MODE(0)) uut (
      .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_wdata(idx_wdata),
      .idx_rdata(idx_rdata), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_be(acc_be),
      .acc_rdata(acc_rdata), .acc_ack(acc_ack), .req_rd(req_rd), .req_wr(req_wr),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .cpl_rdata(cpl_rdata), .cpl_ack(cpl_ack));

   cfg_addr_xlate #(.FIND_MODE(1)) uut_alt (
      .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_wdata(idx_wdata),
      .idx_rdata(idx_rdata_b), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_be(acc_be),
      .acc_rdata(acc_rdata_b), .acc_ack(acc_ack_b), .req_rd(req_rd_b), .req_wr(req_wr_b),
      .req_addr(req_addr_b), .req_wdata(req_wdata_b), .req_be(req_be_b),
      .cpl_rdata(cpl_rdata), .cpl_ack(cpl_ack));

   task automatic chk(input logic ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // independent model of the translation rules
   function automatic logic [31:0] model(input logic [31:0] idx, input logic [11:0] a);
      int d;
      if (idx[31]) return idx | {30'd0, a[1:0]};
      if (idx[0])  return {idx[31:3], a[2:0]};
      d = -1;
      for (int b = 31; b >= 11; b--) if (idx[b]) d = b;
      if (d < 0) return {21'h1FFFFF, idx[10:3], a[2:0]};
      return {16'd0, d[4:0], idx[10:3], a[2:0]};
   endfunction

   task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d,
                         input logic [3:0] be);
      exp_t e;
      @(negedge clk);
      idx_wr    = 1'b0;
      acc_valid = 1'b1;
      acc_write = wr;
      acc_addr  = a;
      acc_wdata = d;
      acc_be    = be;
      e.wr = wr; e.addr = model(shadow, a); e.data = d; e.be = be;
      sb.push_back(e);
      last_addr = e.addr;
   endtask

   // R2: access and index write in the same cycle
   task automatic access_with_write(input logic [31:0] v, input logic [11:0] a);
      exp_t e;
      @(negedge clk);
      idx_wr    = 1'b1;
      idx_wdata = v;
      acc_valid = 1'b1;
      acc_write = 1'b0;
      acc_addr  = a;
      acc_wdata = 32'h0;
      acc_be    = 4'hF;
      e.wr = 1'b0; e.addr = model(shadow, a); e.data = 32'h0; e.be = 4'hF;
      sb.push_back(e);
      last_addr = e.addr;
      shadow = v;
   endtask

   task automatic wr_idx(input logic [31:0] v);
      @(negedge clk);
      acc_valid = 1'b0;
      idx_wr    = 1'b1;
      idx_wdata = v;
      shadow    = v;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         acc_valid = 1'b0;
         idx_wr    = 1'b0;
      end
   endtask

   // monitor: compares both encoder variants against the scoreboard
   always @(negedge clk) begin
      if (rst_n && (req_rd || req_wr || req_rd_b || req_wr_b)) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R3 unexpected strobe", {30'd0, req_wr, req_rd}, 32'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(req_rd == !e.wr && req_wr == e.wr, "R3 strobe kind",
                {30'd0, req_wr, req_rd}, {30'd0, e.wr, !e.wr});
            chk(req_addr == e.addr, "R4-R8 translated address", req_addr, e.addr);
            chk(req_addr_b == e.addr, "R6 alt encoder address", req_addr_b, e.addr);
            chk(req_rd_b == req_rd && req_wr_b == req_wr, "R3 alt strobe",
                {30'd0, req_wr_b, req_rd_b}, {30'd0, req_wr, req_rd});
            chk(req_wdata == e.data, "R9 write data", req_wdata, e.data);
            chk(req_be == e.be, "R9 byte enables", {28'd0, req_be}, {28'd0, e.be});
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(idx_rdata == 32'd0, "R1 reset index", idx_rdata, 32'd0);
      chk(!req_rd && !req_wr, "R3 reset strobes", {30'd0, req_wr, req_rd}, 32'd0);
      rst_n = 1'b1;
      idle(2);
      chk(idx_rdata == 32'd0, "R1 index after reset", idx_rdata, 32'd0);

      // R1, R4: pass-through format
      wr_idx(32'h8000_1234);
      idle(1);
      chk(idx_rdata == 32'h8000_1234, "R1 readback", idx_rdata, 32'h8000_1234);
      access(1'b0, 12'h003, 32'h0, 4'hF);
      access(1'b1, 12'hFFE, 32'hA1B2_C3D4, 4'b0101);  // R11 upper bits ignored
      idle(2);

      // R5: type-1 format
      wr_idx(32'h0001_0A05);
      access(1'b0, 12'h006, 32'h0, 4'hF);
      access(1'b1, 12'hFF2, 32'h1122_3344, 4'b1000); // R11
      idle(2);

      // R6, R8: type-0 one-hot select, every position with rotating function
      for (int b = 11; b <= 30; b++) begin
         wr_idx((32'd1 << b) | ({29'd0, 3'(b)} << 8) | 32'h0000_00A8);
         access(b[0], 12'(b * 37), 32'(b) * 32'h0101_0101, 4'(b));
      end
      idle(2);

      // R6: several select bits, lowest wins
      wr_idx(32'h4012_0000);
      access(1'b0, 12'h005, 32'h0, 4'hF);
      wr_idx(32'h6000_1800 | 32'h0000_0478);
      access(1'b1, 12'h7A1, 32'hDEAD_BEEF, 4'b0011);
      idle(2);

      // R7: empty select fills with ones
      wr_idx(32'h0000_07F8);
      access(1'b0, 12'h002, 32'h0, 4'hF);
      wr_idx(32'h0000_0000);
      access(1'b1, 12'hFFF, 32'h5555_AAAA, 4'b1111);
      idle(2);

      // R2: write and access together, then access with the new value
      wr_idx(32'h8000_0000);
      access_with_write(32'h0000_2005, 12'h001);
      access(1'b0, 12'h004, 32'h0, 4'hF);
      idle(2);

      // R9: outputs hold while idle; R3: no strobes
      idle(3);
      chk(req_addr == last_addr, "R9 hold address", req_addr, last_addr);
      chk(!req_rd && !req_wr, "R3 idle strobes", {30'd0, req_wr, req_rd}, 32'd0);

      // R10: completion path
      @(negedge clk);
      cpl_rdata = 32'hCAFE_F00D;
      cpl_ack   = 1'b1;
      #1;
      chk(acc_rdata == 32'hCAFE_F00D, "R10 read data", acc_rdata, 32'hCAFE_F00D);
      chk(acc_ack == 1'b1, "R10 ack", {31'd0, acc_ack}, 32'd1);
      @(negedge clk);
      cpl_ack = 1'b0;
      #1;
      chk(acc_ack == 1'b0, "R10 ack low", {31'd0, acc_ack}, 32'd0);

      idle(3);
      chk(sb.size() == 0, "R3 missing strobes", sb.size(), 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule